// File: doc/BRIEF.md
# Shared-Memory Coprocessor Launch Bridge

This block joins the expansion bus of a slow host 8-bit computer to the bus of a fast 6502-class coprocessor built on the same chip. Both processors run at the same time and share one window of on-chip RAM. A shared byte has the same 16-bit address on both sides, so the host and the coprocessor do not need to translate addresses. Addresses below the window belong to the coprocessor alone, and hold its zero page and its stack at $0100-$01FF. The host has its own RAM at those addresses.

The host loads a program into the window and writes the coprocessor's start address to two bytes inside it. It then touches a trigger location, with either a read or a write. The first touch releases the coprocessor from reset, and the next touch puts it back into reset. When the coprocessor fetches its reset vector at $FFFC/$FFFD, the bridge returns the two deposited start-address bytes.

The host strobe is asynchronous to the fast clock. The bridge passes it through a two-flop synchroniser and detects its rising edge. Host accesses are never delayed. When a coprocessor access to the shared RAM falls in the same fast cycle as a host access, the bridge drops the coprocessor's ready signal for that one cycle.

The production map uses an 8 KiB private region and the window $2000-$5FFF, set through parameters. The default parameters give a reduced map for verification:
- private region: $0000-$01FF
- shared window: $3C00-$3FFF
- start-address bytes: $3FFC (low) and $3FFD (high)
- trigger: $3FFF

Top module: `cop_share_bridge`

## Requirements
- R1: After reset, `c_rst_n` is 0, `h_rdata` is 8'h00 and `c_rdy` is 1. The coprocessor stays in reset until the first host access to the trigger address.
- R2: Each rising edge of `h_stb` gives exactly one host access. A strobe held high for many cycles on the trigger address toggles `c_rst_n` only once.
- R3: Any host access to `TRIG_ADDR` ($3FFF), read or write, inverts `c_rst_n`.
- R4: A host write inside the shared window [`SHARED_LO`, `SHARED_LO`+`SHARED_BYTES`) is read back by the coprocessor at the same address. A coprocessor write there is read back by the host at the same address.
- R5: Host writes outside the shared window change no storage. Host reads outside the shared window return 8'h00.
- R6: The private region [0, `PRIV_BYTES`) can only be written by the coprocessor, and it keeps its contents through any host activity.
- R7: Coprocessor reads of $FFFC and $FFFD return the bytes held at `START_LO` and `START_LO`+1.
- R8: A coprocessor shared access that falls in a cycle with a host shared access sees `c_rdy`=0 for exactly that cycle, and completes in the next cycle. Private accesses are never stalled.
- R9: `h_rdata` takes the new read data at the fourth rising clock edge, counting the first edge that samples `h_stb` high. It then holds until the next host read completes. Coprocessor read data appears on `c_rdata` in the cycle after the access is accepted.
- R10: Coprocessor accesses outside the private region, the shared window and the two vector addresses return 8'h00 on reads and are ignored on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low reset |
| h_stb | input | 1 | Host access strobe, asynchronous |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 16 | Host address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, held |
| c_req | input | 1 | Coprocessor access request |
| c_we | input | 1 | Coprocessor write (1) or read (0) |
| c_addr | input | 16 | Coprocessor address |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Coprocessor read data |
| c_rdy | output | 1 | Coprocessor ready; 0 stalls the current access |
| c_rst_n | output | 1 | Coprocessor reset, active low |

## Verification
The assertions rely on the following assumptions about the inputs:
- `h_addr`, `h_we` and `h_wdata` stay steady from before `h_strobe` rises until well after it falls.
- `h_stb` stays high for at least three fast cycles and low for at least three.
- The coprocessor holds its request unchanged until `c_rdy` is 1.

Under these conditions, the edge-detected pulse never lasts two cycles, and a stall never lasts two cycles. The bench's host task holds the strobe high for four cycles and low for four, and changes the address only between accesses. Its coprocessor task keeps its request up until it is accepted.

// File: rtl/cpb_pkg.sv
package cpb_pkg;

  // source of the data currently on the coprocessor read path
  typedef enum logic [1:0] {SRC_NONE, SRC_SHARED, SRC_PRIV} csrc_t;

  // true when a lies in [base, base+bytes)
  function automatic logic in_span(input logic [15:0] a, input logic [15:0] base,
                                   input int unsigned bytes);
    int unsigned ai;
    int unsigned bi;
    ai = 32'(a);
    bi = 32'(base);
    return (ai >= bi) && (ai < bi + bytes);
  endfunction

  // reset-vector fetches are redirected to the deposited start address bytes
  function automatic logic [15:0] vec_remap(input logic [15:0] a, input logic [15:0] start_lo);
    if (a == 16'hFFFC) return start_lo;
    if (a == 16'hFFFD) return start_lo + 16'd1;
    return a;
  endfunction

endpackage

// File: rtl/cpb_ram.sv
module cpb_ram #(
  parameter int unsigned DEPTH = 512,
  parameter int          AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cpb_host_sync.sv
module cpb_host_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic pulse
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= stb;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign pulse = s2 & ~s3;

  // one host access per strobe edge: the pulse never spans two cycles
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/cpb_launch.sv
module cpb_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic run
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else if (hit) run <= ~run;
  end

  // run state moves only when a trigger access was seen
  assert_run_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run) |-> $past(hit));
endmodule

// File: rtl/cop_share_bridge.sv
module cop_share_bridge #(
  parameter int unsigned PRIV_BYTES   = 512,
  parameter logic [15:0] SHARED_LO    = 16'h3C00,
  parameter int unsigned SHARED_BYTES = 1024,
  parameter logic [15:0] START_LO     = 16'h3FFC,
  parameter logic [15:0] TRIG_ADDR    = 16'h3FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_stb,
  input  logic        h_we,
  input  logic [15:0] h_addr,
  input  logic [7:0]  h_wdata,
  output logic [7:0]  h_rdata,
  input  logic        c_req,
  input  logic        c_we,
  input  logic [15:0] c_addr,
  input  logic [7:0]  c_wdata,
  output logic [7:0]  c_rdata,
  output logic        c_rdy,
  output logic        c_rst_n
);
  import cpb_pkg::*;

  localparam int PAW = $clog2(PRIV_BYTES);
  localparam int SAW = $clog2(SHARED_BYTES);

  // host side events
  logic go, h_in_win, trig_hit, host_mem;
  cpb_host_sync u_sync (.clk(clk), .rst_n(rst_n), .stb(h_stb), .pulse(go));

  assign h_in_win = in_span(h_addr, SHARED_LO, SHARED_BYTES);
  assign trig_hit = go && (h_addr == TRIG_ADDR);
  assign host_mem = go && h_in_win;

  cpb_launch u_launch (.clk(clk), .rst_n(rst_n), .hit(trig_hit), .run(c_rst_n));

  // coprocessor side decode
  logic [15:0] c_eff;
  logic        c_sh, c_pv, c_stall;
  assign c_eff   = vec_remap(c_addr, START_LO);
  assign c_sh    = c_req && in_span(c_eff, SHARED_LO, SHARED_BYTES);
  assign c_pv    = c_req && in_span(c_eff, 16'h0000, PRIV_BYTES);
  assign c_stall = host_mem && c_sh;
  assign c_rdy   = !c_stall;

  // shared port arbitration: host first
  logic           sh_we;
  logic [SAW-1:0] sh_addr;
  logic [7:0]     sh_wd, sh_rd;
  always_comb begin
    if (host_mem) begin
      sh_we   = h_we;
      sh_addr = SAW'(h_addr - SHARED_LO);
      sh_wd   = h_wdata;
    end else begin
      sh_we   = c_sh && c_we;
      sh_addr = SAW'(c_eff - SHARED_LO);
      sh_wd   = c_wdata;
    end
  end

  cpb_ram #(.DEPTH(SHARED_BYTES), .AW(SAW)) u_shared (
    .clk(clk), .we(sh_we), .addr(sh_addr), .wdata(sh_wd), .rdata(sh_rd));

  logic [7:0] pv_rd;
  cpb_ram #(.DEPTH(PRIV_BYTES), .AW(PAW)) u_priv (
    .clk(clk), .we(c_pv && c_we), .addr(PAW'(c_eff)), .wdata(c_wdata), .rdata(pv_rd));

  // coprocessor read return
  csrc_t csrc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                csrc_q <= SRC_NONE;
    else if (c_sh && !c_stall) csrc_q <= SRC_SHARED;
    else if (c_pv)             csrc_q <= SRC_PRIV;
    else                       csrc_q <= SRC_NONE;
  end

  always_comb begin
    case (csrc_q)
      SRC_SHARED: c_rdata = sh_rd;
      SRC_PRIV:   c_rdata = pv_rd;
      default:    c_rdata = 8'h00;
    endcase
  end

  // host read return, one cycle after the RAM read
  logic hr_v, hr_in;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hr_v    <= 1'b0;
      hr_in   <= 1'b0;
      h_rdata <= 8'h00;
    end else begin
      hr_v  <= go && !h_we;
      hr_in <= h_in_win;
      if (hr_v) h_rdata <= hr_in ? sh_rd : 8'h00;
    end
  end

  assert_stall_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rdy |=> c_rdy);

  assert_priv_nostall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c_pv |-> c_rdy);

  assert_hrdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(h_rdata) |-> $past(hr_v));
endmodule

// File: tb/tb_cop_share_bridge.sv
module tb_cop_share_bridge;
  localparam logic [15:0] SH_LO = 16'h3C00;
  localparam int          SH_N  = 1024;
  localparam int          PV_N  = 512;
  localparam logic [15:0] TRIG  = 16'h3FFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic h_stb = 0, h_we = 0, c_req = 0, c_we = 0;
  logic [15:0] h_addr = 0, c_addr = 0;
  logic [7:0]  h_wdata = 0, c_wdata = 0;
  logic [7:0]  h_rdata, c_rdata;
  logic        c_rdy, c_rst_n;

  int n_chk = 0, n_bad = 0;
  logic exp_run = 1'b0;

  always #2 clk = ~clk;

  cop_share_bridge dut (.*);

  function automatic logic [7:0] pat_h(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] pat_p(input logic [15:0] a);
    return a[7:0] ^ 8'hC3 ^ {a[8], 7'h00};
  endfunction
  function automatic logic [7:0] pat_c(input logic [15:0] a);
    return a[7:0] + 8'h11;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic host_op(input logic we, input logic [15:0] a, input logic [7:0] wd);
    @(negedge clk);
    h_addr = a; h_we = we; h_wdata = wd; h_stb = 1'b1;
    repeat (4) @(negedge clk);
    h_stb = 1'b0;
    repeat (4) @(negedge clk);
    if (a == TRIG) exp_run = ~exp_run;
  endtask

  task automatic cop_op(input logic we, input logic [15:0] a, input logic [7:0] wd,
                        output logic [7:0] rd);
    @(negedge clk);
    c_req = 1'b1; c_we = we; c_addr = a; c_wdata = wd;
    #1;
    while (!c_rdy) begin @(negedge clk); #1; end
    @(negedge clk);
    c_req = 1'b0; c_we = 1'b0;
    #1 rd = c_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [15:0] a;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 c_rst_n", {15'd0, c_rst_n}, 16'd0);
    chk("R1 h_rdata", {8'd0, h_rdata}, 16'd0);
    chk("R1 c_rdy", {15'd0, c_rdy}, 16'd1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 held in reset", {15'd0, c_rst_n}, 16'd0);

    // R4 host fills the window, coprocessor reads at identical addresses
    for (int i = 0; i < SH_N; i++) host_op(1'b1, SH_LO + 16'(i), pat_h(SH_LO + 16'(i)));
    chk("R3 write to trigger starts", {15'd0, c_rst_n}, {15'd0, exp_run});
    for (int i = 0; i < SH_N; i++) begin
      a = SH_LO + 16'(i);
      cop_op(1'b0, a, 8'h00, rd);
      chk("R4 host->cop", {8'd0, rd}, {8'd0, pat_h(a)});
    end

    // R7 reset vector redirection
    cop_op(1'b0, 16'hFFFC, 8'h00, rd);
    chk("R7 vector low", {8'd0, rd}, {8'd0, pat_h(16'h3FFC)});
    cop_op(1'b0, 16'hFFFD, 8'h00, rd);
    chk("R7 vector high", {8'd0, rd}, {8'd0, pat_h(16'h3FFD)});

    // R6 private region, R5 host writes outside window ignored
    for (int i = 0; i < PV_N; i++) cop_op(1'b1, 16'(i), pat_p(16'(i)), rd);
    host_op(1'b1, 16'h0010, 8'hEE);
    host_op(1'b1, 16'h01FF, 8'hEE);
    host_op(1'b1, 16'h3BFF, 8'hEE);
    host_op(1'b1, 16'h8000, 8'hEE);
    for (int i = 0; i < PV_N; i++) begin
      cop_op(1'b0, 16'(i), 8'h00, rd);
      chk("R6 private intact", {8'd0, rd}, {8'd0, pat_p(16'(i))});
    end
    host_op(1'b0, 16'h0010, 8'h00);
    chk("R5 host read private", {8'd0, h_rdata}, 16'd0);
    host_op(1'b0, 16'hFFFC, 8'h00);
    chk("R5 host read unmapped", {8'd0, h_rdata}, 16'd0);
    cop_op(1'b0, SH_LO + 16'h0001, 8'h00, rd);
    chk("R5 window untouched", {8'd0, rd}, {8'd0, pat_h(SH_LO + 16'h0001)});

    // R4 coprocessor fills the window, host reads back; R3 read of trigger stops
    for (int i = 0; i < SH_N; i++) cop_op(1'b1, SH_LO + 16'(i), pat_c(SH_LO + 16'(i)), rd);
    for (int i = 0; i < SH_N; i++) begin
      a = SH_LO + 16'(i);
      host_op(1'b0, a, 8'h00);
      chk("R4 cop->host", {8'd0, h_rdata}, {8'd0, pat_c(a)});
    end
    chk("R3 read of trigger stops", {15'd0, c_rst_n}, {15'd0, exp_run});

    // R10 unmapped coprocessor space
    cop_op(1'b1, 16'h0300, 8'h77, rd);
    cop_op(1'b0, 16'h0300, 8'h00, rd);
    chk("R10 unmapped read", {8'd0, rd}, 16'd0);
    cop_op(1'b0, 16'h8000, 8'h00, rd);
    chk("R10 high unmapped", {8'd0, rd}, 16'd0);

    // R9 host read latency: last host read left pat_c($3FFF)
    @(negedge clk);
    h_addr = SH_LO + 16'd5; h_we = 1'b0; h_stb = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 not before edge 4", {8'd0, h_rdata}, {8'd0, pat_c(TRIG)});
    @(negedge clk);
    chk("R9 at edge 4", {8'd0, h_rdata}, {8'd0, pat_c(SH_LO + 16'd5)});
    h_stb = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 held", {8'd0, h_rdata}, {8'd0, pat_c(SH_LO + 16'd5)});

    // R8 collision: host write and coprocessor shared read in the same cycle
    @(negedge clk);
    h_addr = SH_LO + 16'd7; h_we = 1'b1; h_wdata = 8'hA5; h_stb = 1'b1;
    repeat (2) @(negedge clk);
    c_req = 1'b1; c_we = 1'b0; c_addr = SH_LO + 16'd9;
    #1 chk("R8 stalled", {15'd0, c_rdy}, 16'd0);
    @(negedge clk);
    #1 chk("R8 stall one cycle", {15'd0, c_rdy}, 16'd1);
    @(negedge clk);
    c_req = 1'b0;
    #1 chk("R8 delayed read data", {8'd0, c_rdata}, {8'd0, pat_c(SH_LO + 16'd9)});
    @(negedge clk); h_stb = 1'b0;
    repeat (4) @(negedge clk);
    cop_op(1'b0, SH_LO + 16'd7, 8'h00, rd);
    chk("R8 host write landed", {8'd0, rd}, 16'h00A5);

    // R8 private access during a host access is not stalled
    @(negedge clk);
    h_addr = SH_LO + 16'd3; h_we = 1'b0; h_stb = 1'b1;
    repeat (2) @(negedge clk);
    c_req = 1'b1; c_we = 1'b0; c_addr = 16'h0020;
    #1 chk("R8 private no stall", {15'd0, c_rdy}, 16'd1);
    @(negedge clk);
    c_req = 1'b0;
    #1 chk("R9 private data next cycle", {8'd0, c_rdata}, {8'd0, pat_p(16'h0020)});
    @(negedge clk); h_stb = 1'b0;
    repeat (4) @(negedge clk);

    // R2 long strobe on trigger toggles once
    @(negedge clk);
    h_addr = TRIG; h_we = 1'b0; h_stb = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 one toggle on long strobe", {15'd0, c_rst_n}, {15'd0, ~exp_run});
    h_stb = 1'b0;
    repeat (4) @(negedge clk);
    exp_run = ~exp_run;
    host_op(1'b1, TRIG, 8'h00);
    chk("R3 toggle back", {15'd0, c_rst_n}, {15'd0, exp_run});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule